// File: doc/BRIEF.md
# Eight-Bank DRAM Command Decoder

This block sits on the device side of a graphics DRAM. On each rising clock edge it samples a decoded command code, a 3-bit bank select and a 13-bit address bus. From these it keeps an open or closed flag and a stored row for each of eight internal banks. For column accesses it takes the column address out of a split address field. The auto-precharge bit on the address bus has two roles: on a READ or WRITE it closes the accessed bank after the access, and on a PRECHARGE it closes all banks at once.

A mode-register command passes the address bus through as the register value, and the bank select picks the base register or the extended register. When a command conflicts with the current bank state, the block raises an illegal-command pulse and leaves that state unchanged. A strap input selects a 13-bit row address (1-CS mode) or a 12-bit one. The block captures the strap while reset is low and freezes it once reset is released.

Top module: `dram_bank_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after its release, every bank is closed, every stored row is zero, and `col_valid_o`, `auto_pre_o`, `illegal_o` and `mrs_valid_o` are 0.
- R2: Command code 1 (ACTIVATE) to a closed bank opens the bank named by `ba_i` and stores its row. With the strap captured low, the row is `{1'b0, addr_i[11:0]}`.
- R3: `one_cs_i` is sampled while `rst_n` is low and is ignored once reset is released. If it was captured high, ACTIVATE stores all 13 bits `addr_i[12:0]` as the row.
- R4: Command code 2 (READ) or 3 (WRITE) to an open bank gives `col_valid_o` = 1 in the following cycle only. In that cycle `col_o` = `{addr_i[9], addr_i[7:2]}` and `auto_pre_o` = `addr_i[8]`.
- R5: A legal READ or WRITE with `addr_i[8]` high closes the addressed bank at the same edge. With `addr_i[8]` low, the bank stays open.
- R6: Command code 4 (PRECHARGE) with `addr_i[8]` low closes only the bank named by `ba_i`. With `addr_i[8]` high, it closes all eight banks. A PRECHARGE to a bank that is already closed is legal.
- R7: Command code 5 (mode register set) pulses `mrs_valid_o` for one cycle and sets `mrs_ext_o` = `ba_i[0]` (1 selects the extended register) and `mrs_data_o` = `addr_i`. It changes no bank state.
- R8: An ACTIVATE to an open bank, or a READ or WRITE to a closed bank, raises `illegal_o` for one cycle. Bank flags, stored rows and `col_valid_o` are left unchanged.
- R9: Command codes 0 (NOP), 6 and 7 change no bank state and raise no output pulse.
- R10: Asserting reset after banks have been opened returns every bank to closed with a zero row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous full reset |
| one_cs_i | input | 1 | Row-width strap, captured during reset |
| cmd_i | input | 3 | Command code: 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 mode set |
| ba_i | input | 3 | Bank select |
| addr_i | input | 13 | Address bus |
| bank_open_o | output | 8 | Open flag per bank, bit n for bank n |
| rows_o | output | 104 | Stored row per bank, bank n at bits [13n+12:13n] |
| col_valid_o | output | 1 | Column access accepted in the previous cycle |
| col_o | output | 7 | Decoded column {A9, A7..A2} |
| auto_pre_o | output | 1 | Auto-precharge request of the accepted access |
| mrs_valid_o | output | 1 | Mode-register command accepted in the previous cycle |
| mrs_ext_o | output | 1 | 1 = extended register, 0 = base register |
| mrs_data_o | output | 13 | Mode-register value |
| illegal_o | output | 1 | Conflicting command seen in the previous cycle |

## Verification
The assertions assume that commands arrive only with reset high, and that the strap is meaningful only during reset. They also assume that the bank select addresses all eight banks, with no value outside that range. The stimulus changes inputs only on falling edges and holds reset low for several cycles. It changes the strap only after reset is released, so any effect of the strap after release shows up at the row outputs. Unused command codes are driven only in cycles where no state change is expected.

// File: rtl/bankdec_pkg.sv
package bankdec_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_MRS = 3'd5
    } cmd_e;

    // Position of the dual-role address bit (auto precharge / all banks).
    localparam int AP_BIT = 8;

endpackage

// File: rtl/addr_field_dec.sv
module addr_field_dec #(
    parameter int ADDR_W = 13,
    parameter int COL_W  = 7
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide_row,
    output logic [COL_W-1:0]  col,
    output logic              auto_pre,
    output logic [ADDR_W-1:0] row
);
    import bankdec_pkg::*;

    localparam int NARROW_W = ADDR_W - 1;

    always_comb begin
        // Split column field: A9 above A7..A2, A8 skipped.
        col      = {addr[AP_BIT+1], addr[AP_BIT-1:2]};
        auto_pre = addr[AP_BIT];
        if (wide_row)
            row = addr;
        else
            row = {1'b0, addr[NARROW_W-1:0]};
    end

endmodule

// File: rtl/bank_slot.sv
module bank_slot #(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_en,
    input  logic             close_en,
    input  logic [ROW_W-1:0] row_in,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o
);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (open_en) begin
            slot_d.open = 1'b1;
            slot_d.row  = row_in;
        end else if (close_en) begin
            slot_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign open_o = slot_q.open;
    assign row_o  = slot_q.row;

    // R2: a bank can only open because of an ACTIVATE.
    p_open_needs_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_q.open) |-> $past(open_en));

    // R8: a stored row only moves on an accepted ACTIVATE.
    p_row_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(open_en)) |-> $stable(slot_q.row));

endmodule

// File: rtl/dram_bank_decoder.sv
module dram_bank_decoder #(
    parameter int BANKS  = 8,
    parameter int ADDR_W = 13,
    parameter int COL_W  = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    one_cs_i,
    input  logic [2:0]              cmd_i,
    input  logic [$clog2(BANKS)-1:0] ba_i,
    input  logic [ADDR_W-1:0]       addr_i,
    output logic [BANKS-1:0]        bank_open_o,
    output logic [BANKS*ADDR_W-1:0] rows_o,
    output logic                    col_valid_o,
    output logic [COL_W-1:0]        col_o,
    output logic                    auto_pre_o,
    output logic                    mrs_valid_o,
    output logic                    mrs_ext_o,
    output logic [ADDR_W-1:0]       mrs_data_o,
    output logic                    illegal_o
);
    import bankdec_pkg::*;

    localparam int BA_W = $clog2(BANKS);

    typedef struct packed {
        logic              strap;
        logic              col_valid;
        logic [COL_W-1:0]  col;
        logic              auto_pre;
        logic              mrs_valid;
        logic              mrs_ext;
        logic [ADDR_W-1:0] mrs_data;
        logic              illegal;
        logic [BA_W-1:0]   last_ba;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [COL_W-1:0]  dec_col;
    logic              dec_ap;
    logic [ADDR_W-1:0] dec_row;
    logic [BANKS-1:0]  open_mask, close_mask, bank_open, sel_mask;
    cmd_e              cmd;

    addr_field_dec #(.ADDR_W(ADDR_W), .COL_W(COL_W)) i_field (
        .addr     (addr_i),
        .wide_row (ctl_q.strap),
        .col      (dec_col),
        .auto_pre (dec_ap),
        .row      (dec_row)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        bank_slot #(.ROW_W(ADDR_W)) i_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .open_en  (open_mask[b]),
            .close_en (close_mask[b]),
            .row_in   (dec_row),
            .open_o   (bank_open[b]),
            .row_o    (rows_o[b*ADDR_W +: ADDR_W])
        );
    end

    always_comb begin
        cmd        = cmd_e'(cmd_i);
        sel_mask   = {{(BANKS-1){1'b0}}, 1'b1} << ba_i;
        open_mask  = '0;
        close_mask = '0;
        ctl_d           = ctl_q;
        ctl_d.col_valid = 1'b0;
        ctl_d.mrs_valid = 1'b0;
        ctl_d.illegal   = 1'b0;
        ctl_d.last_ba   = ba_i;
        case (cmd)
            CMD_ACT: begin
                if (bank_open[ba_i]) ctl_d.illegal = 1'b1;
                else                 open_mask     = sel_mask;
            end
            CMD_RD, CMD_WR: begin
                if (!bank_open[ba_i]) begin
                    ctl_d.illegal = 1'b1;
                end else begin
                    ctl_d.col_valid = 1'b1;
                    ctl_d.col       = dec_col;
                    ctl_d.auto_pre  = dec_ap;
                    if (dec_ap) close_mask = sel_mask;
                end
            end
            CMD_PRE: begin
                if (addr_i[AP_BIT]) close_mask = '1;
                else                close_mask = sel_mask;
            end
            CMD_MRS: begin
                ctl_d.mrs_valid = 1'b1;
                ctl_d.mrs_ext   = ba_i[0];
                ctl_d.mrs_data  = addr_i;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.strap <= one_cs_i;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bank_open_o = bank_open;
    assign col_valid_o = ctl_q.col_valid;
    assign col_o       = ctl_q.col;
    assign auto_pre_o  = ctl_q.auto_pre;
    assign mrs_valid_o = ctl_q.mrs_valid;
    assign mrs_ext_o   = ctl_q.mrs_ext;
    assign mrs_data_o  = ctl_q.mrs_data;
    assign illegal_o   = ctl_q.illegal;

    // R3: the strap is frozen once reset has been released.
    p_strap_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(ctl_q.strap));

    // R4: one command yields at most one kind of pulse.
    p_one_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({col_valid_o, mrs_valid_o, illegal_o}) <= 1);

    // R5: an access with auto precharge leaves its bank closed.
    p_ap_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid_o && auto_pre_o) |-> !bank_open[ctl_q.last_ba]);

    // R5: an access without auto precharge leaves its bank open.
    p_no_ap_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid_o && !auto_pre_o) |-> bank_open[ctl_q.last_ba]);

    // R7: a mode-register command leaves bank flags alone.
    p_mrs_no_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_valid_o && $past(rst_n)) |-> bank_open == $past(bank_open));

    // R8: a rejected command leaves bank flags alone.
    p_illegal_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_o && $past(rst_n)) |-> bank_open == $past(bank_open));

endmodule

// File: tb/test_dram_bank_decoder.sv
module test_dram_bank_decoder;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         one_cs_i = 1'b0;
    logic [2:0]   cmd_i = 3'd0;
    logic [2:0]   ba_i = 3'd0;
    logic [12:0]  addr_i = '0;
    logic [7:0]   bank_open_o;
    logic [103:0] rows_o;
    logic         col_valid_o, auto_pre_o, mrs_valid_o, mrs_ext_o, illegal_o;
    logic [6:0]   col_o;
    logic [12:0]  mrs_data_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dram_bank_decoder i_dram_bank_decoder (
        .clk(clk), .rst_n(rst_n), .one_cs_i(one_cs_i), .cmd_i(cmd_i),
        .ba_i(ba_i), .addr_i(addr_i), .bank_open_o(bank_open_o),
        .rows_o(rows_o), .col_valid_o(col_valid_o), .col_o(col_o),
        .auto_pre_o(auto_pre_o), .mrs_valid_o(mrs_valid_o),
        .mrs_ext_o(mrs_ext_o), .mrs_data_o(mrs_data_o),
        .illegal_o(illegal_o)
    );

    // {cmd, ba, addr, open, col_valid, col, auto_pre, illegal, mrs_valid}
    localparam int NV = 13;
    localparam logic [37:0] VEC [NV] = '{
        {3'd1, 3'd0, 13'h0ABC, 8'h01, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0}, // R2
        {3'd1, 3'd3, 13'h1123, 8'h09, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0}, // R2
        {3'd2, 3'd0, 13'h02A8, 8'h09, 1'b1, 7'h6A, 1'b0, 1'b0, 1'b0}, // R4 R5
        {3'd3, 3'd3, 13'h011C, 8'h01, 1'b1, 7'h07, 1'b1, 1'b0, 1'b0}, // R4 R5
        {3'd2, 3'd3, 13'h0000, 8'h01, 1'b0, 7'h00, 1'b0, 1'b1, 1'b0}, // R8
        {3'd1, 3'd0, 13'h0777, 8'h01, 1'b0, 7'h00, 1'b0, 1'b1, 1'b0}, // R8
        {3'd1, 3'd7, 13'h0055, 8'h81, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0}, // R2
        {3'd1, 3'd5, 13'h0000, 8'hA1, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0}, // R2
        {3'd4, 3'd7, 13'h0000, 8'h21, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0}, // R6
        {3'd5, 3'd1, 13'h0333, 8'h21, 1'b0, 7'h00, 1'b0, 1'b0, 1'b1}, // R7
        {3'd6, 3'd2, 13'h1FFF, 8'h21, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0}, // R9
        {3'd4, 3'd2, 13'h0100, 8'h00, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0}, // R6
        {3'd3, 3'd0, 13'h0000, 8'h00, 1'b0, 7'h00, 1'b0, 1'b1, 1'b0}  // R8
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge sample, check at the next fall.
    task automatic issue(input logic [2:0] c, input logic [2:0] b, input logic [12:0] a);
        cmd_i = c; ba_i = b; addr_i = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0; one_cs_i = strap; cmd_i = 3'd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [12:0] row_of(input int b);
        return rows_o[b*13 +: 13];
    endfunction

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    errors++;
                    $display("FAIL watchdog expired");
                    $display("CHECKS %0d ERRORS %0d", checks, errors);
                    $finish;
                end
            end
        join_none

        do_reset(1'b0);
        // R1: default state after reset
        chk("R1", "open", 32'(bank_open_o), 32'h0);
        chk("R1", "rows", 32'(rows_o != '0), 32'h0);
        chk("R1", "pulses", 32'({col_valid_o, auto_pre_o, illegal_o, mrs_valid_o}), 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [37:0] v;
            v = VEC[i];
            issue(v[37:35], v[34:32], v[31:19]);
            chk("R2/R5/R6/R9", $sformatf("vec%0d open", i), 32'(bank_open_o), 32'(v[18:11]));
            chk("R4", $sformatf("vec%0d col_valid", i), 32'(col_valid_o), 32'(v[10]));
            if (v[10]) begin
                chk("R4", $sformatf("vec%0d col", i), 32'(col_o), 32'(v[9:3]));
                chk("R4", $sformatf("vec%0d auto_pre", i), 32'(auto_pre_o), 32'(v[2]));
            end
            chk("R8", $sformatf("vec%0d illegal", i), 32'(illegal_o), 32'(v[1]));
            chk("R7", $sformatf("vec%0d mrs_valid", i), 32'(mrs_valid_o), 32'(v[0]));
            if (i == 1) begin
                chk("R2", "bank0 row", 32'(row_of(0)), 32'h0ABC);
                chk("R2", "bank3 row narrow", 32'(row_of(3)), 32'h0123);
            end
            if (i == 5) chk("R8", "bank0 row kept", 32'(row_of(0)), 32'h0ABC);
        end

        // R2: narrow row drops A12
        issue(3'd1, 3'd1, 13'h1FFF);
        chk("R2", "bank1 row", 32'(row_of(1)), 32'h0FFF);
        // R7: base and extended register select
        issue(3'd5, 3'd1, 13'h0155);
        chk("R7", "ext", 32'(mrs_ext_o), 32'h1);
        chk("R7", "data", 32'(mrs_data_o), 32'h0155);
        issue(3'd5, 3'd0, 13'h1AAA);
        chk("R7", "base", 32'(mrs_ext_o), 32'h0);
        chk("R7", "data2", 32'(mrs_data_o), 32'h1AAA);
        chk("R7", "open kept", 32'(bank_open_o), 32'h02);
        issue(3'd0, 3'd0, 13'h0000);
        chk("R7", "mrs single pulse", 32'(mrs_valid_o), 32'h0);

        // R10: reset mid-operation, strap captured high
        do_reset(1'b1);
        chk("R10", "open cleared", 32'(bank_open_o), 32'h0);
        chk("R10", "row cleared", 32'(row_of(1)), 32'h0);
        one_cs_i = 1'b0;   // ignored after release
        issue(3'd1, 3'd2, 13'h1ABC);
        chk("R3", "wide row", 32'(row_of(2)), 32'h1ABC);
        issue(3'd1, 3'd4, 13'h1FFF);
        chk("R3", "strap ignored", 32'(row_of(4)), 32'h1FFF);
        // R5: access without auto precharge keeps bank open
        issue(3'd3, 3'd2, 13'h0204);
        chk("R5", "bank2 open", 32'(bank_open_o), 32'h14);
        chk("R4", "col", 32'(col_o), 32'h41);
        issue(3'd7, 3'd4, 13'h0100);
        chk("R9", "code7 no change", 32'(bank_open_o), 32'h14);
        chk("R4", "col_valid single", 32'(col_valid_o), 32'h0);
        chk("R9", "no pulse", 32'({illegal_o, mrs_valid_o}), 32'h0);
        // R6: precharge to an already closed bank is legal
        issue(3'd4, 3'd0, 13'h0000);
        chk("R6", "closed bank pre", 32'({illegal_o, bank_open_o}), 32'h14);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule